// File: doc/BRIEF.md
# Serial Octal Low-Side Switch Controller

This block is the digital core of an eight-channel low-side power switch that a host commands over a slow serial link. A fast system clock oversamples the link pins: a serial clock, a serial data input, an active-low frame enable and an active-low reset. Command bits shift into a channel-wide register. When the frame enable rises, the register is copied into the channel latch, and that latch drives the switches. A latch bit of 1 turns its channel off. A latch bit of 0 turns it on.

When the frame enable falls, the block captures one output-sense bit per channel. It then returns those bits on the serial output, highest channel first, while the new command shifts in. Bits keep flowing from input to output for as long as the host clocks, so several blocks can be chained. The serial output is released, and its enable dropped, whenever the frame is idle or reset is held.

Each latch update starts a blanking window of a parameter number of system cycles. During the window the sense inputs cannot change the latch. After it ends, any channel that is on and whose sense input reports a high output is forced off. The channel stays off until the next latch update. The analog parts of the switch appear here only as the sense inputs.

Top module: `osw_top`

## Requirements
- R1: While `ser_rst_n` is low, without waiting for a clock edge, `chan_off` is all ones and `ser_dout_en` is 0.
- R2: When the frame enable falls, the sense inputs are captured. `ser_dout` then presents the bit for channel 7 and, after each rising link-clock edge, the next lower channel, down to channel 0 on the eighth rising edge.
- R3: While the frame is enabled, `ser_din` is taken on each falling link-clock edge into bit 0 of the shift register. The first bit sent lands on channel 7 and the last on channel 0.
- R4: While a frame is active, `ser_dout` changes only after a rising link-clock edge or at the start of a frame.
- R5: `ser_dout_en` is 1 while `ser_en_n` is low and 0 while it is high.
- R6: Link-clock edges while `ser_en_n` is high leave the shift register and `chan_off` unchanged.
- R7: On the rising edge of the frame enable, the shift register is copied to `chan_off`, where bit i controls channel i and 1 means off.
- R8: For BLANK_CYC system cycles after a latch update, a high sense input does not change `chan_off`. After that, an on channel with its sense input high is set to 1 and held until the next latch update.
- R9: Bits shifted in during clock pulses beyond the eighth in a frame appear on `ser_dout` eight rising edges after they entered, in the order sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the link |
| ser_rst_n | input | 1 | Active-low asynchronous reset; all channels off |
| ser_clk | input | 1 | Link clock |
| ser_din | input | 1 | Link serial data in (1 = channel off) |
| ser_en_n | input | 1 | Active-low frame enable |
| sense_hi | input | 8 | Per-channel sense: 1 = channel output above threshold |
| ser_dout | output | 1 | Link serial data out |
| ser_dout_en | output | 1 | Drive enable for the serial output pad |
| chan_off | output | 8 | Channel latch: 1 = switch off |

## Verification
A shift register that is misaligned or loaded at the wrong edge corrupts the status stream on `ser_dout` at the first rising link-clock edge of a frame. It also leaves the wrong pattern in `chan_off` once the enable rises. A blanking counter that is too short, or that never expires, shows up in `chan_off` either during the window or just after it, because a channel that is commanded on while its sense input is high gets forced off too early or never. A chained frame of sixteen clocks shows within eight rising edges whether the first byte passes through intact.

// File: rtl/osw_pkg.sv
package osw_pkg;
    localparam int unsigned OSW_CHANNELS  = 8;
    localparam int unsigned OSW_SYNC_BITS = 3;

    typedef struct packed {
        logic rise;
        logic fall;
    } osw_edge_t;

    function automatic osw_edge_t osw_detect(input logic prev, input logic now);
        osw_edge_t e;
        e.rise = now & ~prev;
        e.fall = prev & ~now;
        return e;
    endfunction
endpackage

// File: rtl/osw_sync.sv
module osw_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {RST_VAL, RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/osw_frame.sv
module osw_frame
    import osw_pkg::*;
#(
    parameter int unsigned N_CH = OSW_CHANNELS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            din_s,
    input  logic            en_n_s,
    input  logic [N_CH-1:0] sense_s,
    output logic [N_CH-1:0] shreg_o,
    output logic            dout_o,
    output logic            dout_en_o,
    output logic            commit_o
);
    typedef struct packed {
        logic            sclk_prev;
        logic            en_prev;
        logic [N_CH-1:0] shreg;
        logic            dout;
        logic            dout_en;
    } frame_st_t;

    frame_st_t st_d, st_q;
    osw_edge_t clk_edge, en_edge;

    always_comb begin
        clk_edge = osw_detect(st_q.sclk_prev, sclk_s);
        en_edge  = osw_detect(st_q.en_prev, en_n_s);

        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.en_prev   = en_n_s;
        st_d.dout_en   = ~en_n_s;

        if (en_edge.fall) begin
            st_d.shreg = sense_s;
            st_d.dout  = sense_s[N_CH-1];
        end else if (!en_n_s) begin
            if (clk_edge.fall) begin
                st_d.shreg = {st_q.shreg[N_CH-2:0], din_s};
            end
            if (clk_edge.rise) begin
                st_d.dout = st_q.shreg[N_CH-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.en_prev   <= 1'b1;
            st_q.shreg     <= '0;
            st_q.dout      <= 1'b0;
            st_q.dout_en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg_o   = st_q.shreg;
    assign dout_o    = st_q.dout;
    assign dout_en_o = st_q.dout_en;
    assign commit_o  = en_edge.rise;

    assert_capture_sense_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_edge.fall |=> (st_q.shreg == $past(sense_s)));

    assert_dout_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_edge.rise && !en_edge.fall) |=> $stable(st_q.dout));

    assert_release_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> !dout_en_o);

    assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> $stable(st_q.shreg));
endmodule

// File: rtl/osw_latch.sv
module osw_latch #(
    parameter int unsigned N_CH      = 8,
    parameter int unsigned BLANK_CYC = 20000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic [N_CH-1:0] shreg_i,
    input  logic [N_CH-1:0] sense_s,
    output logic [N_CH-1:0] off_o
);
    localparam int unsigned CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);

    typedef struct packed {
        logic [N_CH-1:0] lat;
        logic [CW-1:0]   blank;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.lat   = shreg_i;
            st_d.blank = BLANK_V;
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - 1'b1;
        end else begin
            st_d.lat = st_q.lat | sense_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat   <= '1;
            st_q.blank <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign off_o = st_q.lat;

    assert_commit_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (off_o == $past(shreg_i)));

    assert_blank_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank != '0 && !commit_i) |=> $stable(off_o));

    assert_fault_only_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ((off_o & $past(off_o)) == $past(off_o)));
endmodule

// File: rtl/osw_top.sv
module osw_top
    import osw_pkg::*;
#(
    parameter int unsigned N_CH      = OSW_CHANNELS,
    parameter int unsigned BLANK_CYC = 20000
) (
    input  logic            clk,
    input  logic            ser_rst_n,
    input  logic            ser_clk,
    input  logic            ser_din,
    input  logic            ser_en_n,
    input  logic [N_CH-1:0] sense_hi,
    output logic            ser_dout,
    output logic            ser_dout_en,
    output logic [N_CH-1:0] chan_off
);
    logic [OSW_SYNC_BITS-1:0] link_s;
    logic [N_CH-1:0]          sense_s;
    logic [N_CH-1:0]          shreg;
    logic                     commit;

    osw_sync #(.WIDTH(OSW_SYNC_BITS), .RST_VAL(3'b001)) u_link_sync (
        .clk    (clk),
        .rst_n  (ser_rst_n),
        .async_i({ser_clk, ser_din, ser_en_n}),
        .sync_o (link_s)
    );

    osw_sync #(.WIDTH(N_CH), .RST_VAL('0)) u_sense_sync (
        .clk    (clk),
        .rst_n  (ser_rst_n),
        .async_i(sense_hi),
        .sync_o (sense_s)
    );

    osw_frame #(.N_CH(N_CH)) u_frame (
        .clk      (clk),
        .rst_n    (ser_rst_n),
        .sclk_s   (link_s[2]),
        .din_s    (link_s[1]),
        .en_n_s   (link_s[0]),
        .sense_s  (sense_s),
        .shreg_o  (shreg),
        .dout_o   (ser_dout),
        .dout_en_o(ser_dout_en),
        .commit_o (commit)
    );

    osw_latch #(.N_CH(N_CH), .BLANK_CYC(BLANK_CYC)) u_latch (
        .clk     (clk),
        .rst_n   (ser_rst_n),
        .commit_i(commit),
        .shreg_i (shreg),
        .sense_s (sense_s),
        .off_o   (chan_off)
    );
endmodule

// File: tb/osw_top_bench.sv
module osw_top_bench;
    localparam int BLANK = 40;

    logic       clk = 1'b0;
    logic       ser_rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_en_n = 1'b1;
    logic [7:0] sense_hi = 8'h00;
    logic       ser_dout;
    logic       ser_dout_en;
    logic [7:0] chan_off;

    int n_chk = 0;
    int n_fail = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    osw_top #(.N_CH(8), .BLANK_CYC(BLANK)) u_osw_top (
        .clk        (clk),
        .ser_rst_n  (ser_rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_en_n   (ser_en_n),
        .sense_hi   (sense_hi),
        .ser_dout   (ser_dout),
        .ser_dout_en(ser_dout_en),
        .chan_off   (chan_off)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: each rising link clock yields one expected serial bit
    initial begin
        forever begin
            @(posedge ser_clk);
            repeat (6) @(negedge clk);
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {7'd0, ser_dout}, {7'd0, e});
            end
        end
    end

    // driver: one frame of nclk bits, first bit sent is word[nclk-1]
    task automatic run_frame(input logic [15:0] word, input int nclk,
                             input logic [7:0] status, input logic [7:0] sense_after);
        ser_en_n = 1'b0;
        cyc(8);
        chk("R5 enable in frame", {7'd0, ser_dout_en}, 8'h01);
        chk("R2 first status bit", {7'd0, ser_dout}, {7'd0, status[7]});
        for (int k = 0; k < nclk; k++) begin
            ser_din = word[nclk-1-k];
            if (k < 8) begin
                exp_q.push_back(status[7-k]);
                tag_q.push_back("R2 status stream");
            end else begin
                exp_q.push_back(word[nclk-1-(k-8)]);
                tag_q.push_back("R9 pass-through");
            end
            cyc(4);
            ser_clk = 1'b1;
            cyc(8);
            ser_clk = 1'b0;
            cyc(8);
        end
        ser_en_n = 1'b1;
        sense_hi = sense_after;
        cyc(8);
        chk("R5 released when idle", {7'd0, ser_dout_en}, 8'h00);
    endtask

    initial begin
        cyc(4);
        chk("R1 reset channels off", chan_off, 8'hFF);
        chk("R1 reset output released", {7'd0, ser_dout_en}, 8'h00);
        ser_rst_n = 1'b1;
        cyc(8);
        chk("R1 off after release", chan_off, 8'hFF);

        // R3 / R7: command pattern, status pattern A5
        sense_hi = 8'hA5;
        cyc(4);
        run_frame(16'h003C, 8, 8'hA5, 8'h00);
        chk("R3 R7 latch from shift", chan_off, 8'h3C);
        cyc(60);
        chk("R7 latch holds", chan_off, 8'h3C);

        // second pattern, all on
        sense_hi = 8'h3C;
        cyc(4);
        run_frame(16'h0000, 8, 8'h3C, 8'h00);
        chk("R7 all on", chan_off, 8'h00);

        // R6: link clock while idle
        ser_din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b1; cyc(8);
            ser_clk = 1'b0; cyc(8);
        end
        chk("R6 idle clocks keep latch", chan_off, 8'h00);
        chk("R6 idle clocks keep output released", {7'd0, ser_dout_en}, 8'h00);
        run_frame(16'h0081, 8, 8'h00, 8'h00);
        chk("R6 R3 clean shift after idle clocks", chan_off, 8'h81);

        // R9: sixteen-clock chained frame
        sense_hi = 8'h81;
        cyc(4);
        run_frame(16'hC35A, 16, 8'h81, 8'h00);
        chk("R9 last byte latched", chan_off, 8'h5A);

        // R8: blanking then fault latch-off
        run_frame(16'h0000, 8, 8'h00, 8'h24);
        chk("R8 blank window ignores sense", chan_off, 8'h00);
        cyc(50);
        chk("R8 fault forces off", chan_off, 8'h24);
        sense_hi = 8'h00;
        cyc(20);
        chk("R8 fault held", chan_off, 8'h24);
        sense_hi = 8'h24;
        cyc(4);
        run_frame(16'h0000, 8, 8'h24, 8'h00);
        cyc(60);
        chk("R8 reload clears fault", chan_off, 8'h00);

        // R1: asynchronous reset mid-frame
        ser_en_n = 1'b0;
        cyc(8);
        ser_clk = 1'b1; cyc(8);
        ser_clk = 1'b0; cyc(4);
        ser_rst_n = 1'b0;
        #1;
        chk("R1 async reset channels off", chan_off, 8'hFF);
        chk("R1 async reset releases output", {7'd0, ser_dout_en}, 8'h00);
        ser_en_n = 1'b1;
        cyc(4);
        ser_rst_n = 1'b1;
        cyc(8);
        chk("R1 stays off after reset", chan_off, 8'hFF);
        if (exp_q.size() != 0) chk("R2 stream drained", 8'(exp_q.size()), 8'h00);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule